// File: doc/BRIEF.md
# Serial Configuration Bit Store

This block stands in for a one-bit-wide, read-only configuration store that an FPGA loading itself in master serial mode reads one bit per clock. A sequential address pointer walks a bit array of parameterized depth. Every stored bit comes from a fixed pattern function of its address, so no memory is instantiated and any depth elaborates cheaply. The loading device supplies the clock, and its active-low chip select and the combined reset/output-enable pin decide whether the pointer moves and whether the data pin is driven.

The reset/output-enable input has a polarity chosen by a parameter. At its reset level it clears the pointer and floats the data pin. A high chip select also clears the pointer and floats the data pin, and it signals low-power standby. The pointer does not wrap: it stops on the last address and keeps presenting that bit for as long as clocks continue. The tri-state pin is modelled as a data bit plus a drive flag.

Top module: `serial_cfg_store`

## Requirements
- R1: On a rising `clk` edge the address pointer advances by one only while `sel_n` is 0 and `rst_oe` is at its inactive level. In any other case it does not advance.
- R2: While `rst_oe` is at its reset level, the pointer is held at 0 at once, without waiting for a clock edge, and `dout_en` is 0.
- R3: With `RESET_HIGH`=1 the reset level of `rst_oe` is 1. With `RESET_HIGH`=0 it is 0. The default is 1.
- R4: While `sel_n` is 1, the pointer is held at 0 and `dout_en` is 0, whatever the level of `rst_oe`.
- R5: Once the pointer reaches the last address, DEPTH-1, further enabled edges leave it there. `dout` then keeps showing the bit at DEPTH-1.
- R6: After any reset or deselect ends, the first bit on `dout` is the bit at address 0. It is shown before the next clock edge.
- R7: The bit stored at address a is the XOR reduction of (a AND `PAT_MASK`), XORed with `PAT_INV`.
- R8: `dout_en` is 1 exactly when `sel_n` is 0 and `rst_oe` is inactive. While `dout_en` is 0, `dout` is 0. While it is 1, `dout` carries the bit at the current address.
- R9: `standby` equals `sel_n` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock supplied by the loading device |
| sel_n | input | 1 | Chip select, active low; 1 clears the pointer and enters standby |
| rst_oe | input | 1 | Combined pointer reset / output enable; polarity set by RESET_HIGH |
| dout | output | 1 | Serial data bit, 0 when not driven |
| dout_en | output | 1 | High when the data pin is actively driven |
| standby | output | 1 | High while the store is in low-power standby |

## Verification
The bench tries the control pair (`sel_n`, `rst_oe`) in several patterns. Long enabled runs show the address stepping, and a stored pattern chosen to be irregular tells a stalled or skipped address apart from a correct one. Short pulses of reset and of deselect in the middle of a run show whether the pointer truly returns to address 0: it must be the zero bit that appears right after release, not a bit from where the run left off. Deselect with reset inactive is kept apart from reset with select active, and this separates the standby flag from the drive flag. Two copies of the block with opposite reset polarity get the same logical stimulus and must give the same output stream. A run past the end of the array shows saturation as opposed to wrap-around.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

   typedef struct packed {
      logic clear;    // pointer held at zero
      logic drive;    // data pin driven
      logic standby;  // low-power state
   } scfg_ctl_t;

   function automatic logic scfg_pattern_bit(input logic [31:0] addr,
                                             input logic [31:0] mask,
                                             input logic        inv);
      return (^(addr & mask)) ^ inv;
   endfunction

endpackage

// File: rtl/scfg_ctl_decode.sv
module scfg_ctl_decode
   import scfg_pkg::*;
#(
   parameter bit RESET_HIGH = 1'b1
) (
   input  logic      sel_n,
   input  logic      rst_oe,
   output scfg_ctl_t ctl
);
   logic rst_lvl;

   generate
      if (RESET_HIGH) begin : g_pol_high
         assign rst_lvl = rst_oe;
      end else begin : g_pol_low
         assign rst_lvl = ~rst_oe;
      end
   endgenerate

   always_comb begin
      ctl.clear   = rst_lvl | sel_n;
      ctl.drive   = ~rst_lvl & ~sel_n;
      ctl.standby = sel_n;
   end

   // R8: drive and clear are never both set
   always_comb begin
      a_drive_excl_r8 : assert (!(ctl.drive && ctl.clear));
   end
endmodule

// File: rtl/scfg_addr_counter.sv
module scfg_addr_counter #(
   parameter int DEPTH  = 197696,
   parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              clear,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

   always_ff @(posedge clk or posedge clear) begin
      if (clear)
         addr <= '0;
      else if (addr != LAST)
         addr <= addr + 1'b1;
   end

   p_step_r1 : assert property (@(posedge clk) disable iff (clear)
      (addr != LAST) |=> (addr == $past(addr) + 1'b1));
   p_hold_last_r5 : assert property (@(posedge clk) disable iff (clear)
      (addr == LAST) |=> (addr == LAST));
   p_zero_clear_r2 : assert property (@(posedge clk)
      clear |-> (addr == '0));
endmodule

// File: rtl/scfg_bit_source.sv
module scfg_bit_source
   import scfg_pkg::*;
#(
   parameter int          ADDR_W   = 18,
   parameter logic [31:0] PAT_MASK = 32'h0002_D5A7,
   parameter bit          PAT_INV  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              bit_out
);
   always_comb bit_out = scfg_pattern_bit(32'(addr), PAT_MASK, PAT_INV);
endmodule

// File: rtl/serial_cfg_store.sv
module serial_cfg_store
   import scfg_pkg::*;
#(
   parameter int          DEPTH      = 197696,
   parameter bit          RESET_HIGH = 1'b1,
   parameter logic [31:0] PAT_MASK   = 32'h0002_D5A7,
   parameter bit          PAT_INV    = 1'b1
) (
   input  logic clk,
   input  logic sel_n,
   input  logic rst_oe,
   output logic dout,
   output logic dout_en,
   output logic standby
);
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("serial_cfg_store: DEPTH must be at least 2");
      end
      if (DEPTH > 32'h7FFF_FFFF) begin : g_bad_depth_hi
         $error("serial_cfg_store: DEPTH exceeds 31-bit address range");
      end
   endgenerate

   scfg_ctl_t         ctl;
   logic [ADDR_W-1:0] addr;
   logic              raw_bit;

   scfg_ctl_decode #(.RESET_HIGH(RESET_HIGH)) u_decode (
      .sel_n  (sel_n),
      .rst_oe (rst_oe),
      .ctl    (ctl)
   );

   scfg_addr_counter #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_counter (
      .clk   (clk),
      .clear (ctl.clear),
      .addr  (addr)
   );

   scfg_bit_source #(.ADDR_W(ADDR_W), .PAT_MASK(PAT_MASK), .PAT_INV(PAT_INV)) u_bits (
      .addr    (addr),
      .bit_out (raw_bit)
   );

   assign dout    = ctl.drive & raw_bit;
   assign dout_en = ctl.drive;
   assign standby = ctl.standby;

   p_standby_quiet_r4 : assert property (@(posedge clk) disable iff (ctl.clear && !sel_n)
      standby |-> !dout_en);
   p_restart_zero_r6 : assert property (@(posedge clk) disable iff (ctl.clear)
      $rose(dout_en) |-> (addr == '0));
   p_idle_low_r8 : assert property (@(posedge clk)
      !dout_en |-> !dout);
endmodule

// File: tb/serial_cfg_store_tb_top.sv
module serial_cfg_store_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int          DEPTH = 12;
   localparam logic [31:0] MASK  = 32'h0000_000B;
   localparam bit          INV   = 1'b0;

   logic clk = 1'b0;
   logic sel_n, rst_hi, rst_lo;
   logic dout_a, en_a, sb_a, dout_b, en_b, sb_b;
   int   n_checks = 0, n_fail = 0;
   int   maddr = 0;
   bit   done = 0;

   always #2 clk = ~clk;

   serial_cfg_store #(.DEPTH(DEPTH), .RESET_HIGH(1'b1), .PAT_MASK(MASK), .PAT_INV(INV)) dut_i (
      .clk(clk), .sel_n(sel_n), .rst_oe(rst_hi), .dout(dout_a), .dout_en(en_a), .standby(sb_a));
   serial_cfg_store #(.DEPTH(DEPTH), .RESET_HIGH(1'b0), .PAT_MASK(MASK), .PAT_INV(INV)) dut_lo_i (
      .clk(clk), .sel_n(sel_n), .rst_oe(rst_lo), .dout(dout_b), .dout_en(en_b), .standby(sb_b));

   // R7 reference: XOR reduction of (a AND mask), XOR inv
   function automatic logic ref_bit(input int a);
      logic [31:0] v;
      v = 32'(a) & MASK;
      return (^v) ^ INV;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
      end
   endtask

   logic s_cur = 1'b1, r_cur = 1'b1;

   task automatic check_all(input string ctx);
      logic en_exp, d_exp;
      en_exp = !s_cur && !r_cur;
      d_exp  = en_exp ? ref_bit(maddr) : 1'b0;
      check({"R8 en hi-pol ", ctx}, en_a, en_exp);
      check({"R3 en lo-pol ", ctx}, en_b, en_exp);
      check({"R9 standby ", ctx}, sb_a, s_cur);
      check({"R4 standby lo-pol ", ctx}, sb_b, s_cur);
      check({"R7 data hi-pol ", ctx}, dout_a, d_exp);
      check({"R3 data lo-pol ", ctx}, dout_b, d_exp);
   endtask

   // drive at negedge; R2/R4 clear acts at once; check before and after next edge
   task automatic step(input logic s, input logic r);
      @(negedge clk);
      s_cur = s; r_cur = r;
      sel_n = s; rst_hi = r; rst_lo = ~r;
      if (s || r) maddr = 0;
      #0.5 check_all("pre-edge");
      @(posedge clk);
      if (!s && !r && maddr < DEPTH - 1) maddr++;   // R1, R5
      #0.5 check_all("post-edge");
   endtask

   // {sel_n, rst_level, hold cycles}
   localparam logic [5:0] VEC [16] = '{
      {1'b0, 1'b1, 4'd2}, {1'b0, 1'b0, 4'd5}, {1'b0, 1'b1, 4'd1}, {1'b0, 1'b0, 4'd3},
      {1'b1, 1'b0, 4'd2}, {1'b0, 1'b0, 4'd4}, {1'b1, 1'b1, 4'd1}, {1'b0, 1'b0, 4'd6},
      {1'b0, 1'b1, 4'd3}, {1'b1, 1'b0, 4'd1}, {1'b0, 1'b0, 4'd2}, {1'b1, 1'b1, 4'd2},
      {1'b0, 1'b0, 4'd1}, {1'b0, 1'b1, 4'd1}, {1'b0, 1'b0, 4'd7}, {1'b1, 1'b0, 4'd1}};

   initial begin
      sel_n = 1'b1; rst_hi = 1'b1; rst_lo = 1'b0;
      #1 check("R9 standby at reset", sb_a, 1'b1);
      check("R2 no drive at reset", en_a, 1'b0);
      check("R8 dout low at reset", dout_a, 1'b0);

      for (int i = 0; i < 16; i++) begin
         for (int k = 0; k < int'(VEC[i][3:0]); k++) step(VEC[i][5], VEC[i][4]);
      end

      // R6: release from reset shows address 0 before any edge
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      // R5: run well past the last address; bit at DEPTH-1 persists
      for (int k = 0; k < 2 * DEPTH; k++) step(1'b0, 1'b0);
      check("R5 saturated bit", dout_a, ref_bit(DEPTH - 1));
      check("R5 pointer at end", (maddr == DEPTH - 1) ? 1'b1 : 1'b0, 1'b1);
      // R4: deselect alone restarts from 0
      step(1'b1, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      // R1: reset level held across edges keeps the pointer at 0
      step(1'b0, 1'b1);
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            #400000;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule